// File: doc/BRIEF.md
# Hang and Stack-Fault Reset Supervisor

This block sits beside a small processor core and watches for three ways the core can lose control: a watchdog that is not cleared in time, a return-address stack that is pushed past its capacity or popped while empty, and a low supply flag from an analog comparator outside the block. Any of these pulls a single active-low fault line low. The line is meant to be wired back to the core's reset input, so a fault restarts the system.

The block holds the core's return-address stack itself: five entries of 13 bits. The core pushes a return address on a call or interrupt and pops it on a return. The popped address and the current depth are presented at the outputs. Up to three of the five levels may be taken by nested interrupts; the block makes no distinction between call and interrupt pushes. The watchdog advances on a tick from an interval timer and restarts on a clear strobe issued by software. A three-bit cause register records which conditions have fired. The cause register and the fault line hold their value until the reset input is applied. The reset clears the stack depth, the watchdog count and the causes.

Top module: `hang_supervisor`

## Requirements
- R1: After reset, `depth_o` is 0, `pop_addr_o` is 0, `cause_o` is 0 and `fault_n_o` is 1.
- R2: A push alone with depth below 5 stores `push_addr_i` and raises `depth_o` by one after the clock edge. A pop alone with depth above 0 lowers `depth_o` by one and, after the same edge, shows the most recently pushed unpopped address on `pop_addr_o` (last in, first out).
- R3: A push alone at depth 5 is an overflow. It sets `cause_o[1]`, and the depth and all stored entries stay unchanged.
- R4: A pop alone at depth 0 is an underflow. It sets `cause_o[1]`, and `pop_addr_o` and the depth stay unchanged.
- R5: Push and pop asserted in the same cycle have no effect on the depth, the entries or `pop_addr_o`, and raise no fault.
- R6: The watchdog count rises by one per `tick_i`. The WD_LIMIT-th tick since the last clear or reset sets `cause_o[0]`, and that tick returns the count to 0.
- R7: `wd_clear_i` sets the watchdog count to 0 and takes priority over a tick in the same cycle. That tick neither counts nor overflows.
- R8: `lowv_i` high at a clock edge sets `cause_o[2]`.
- R9: `fault_n_o` is 0 exactly when any bit of `cause_o` is 1. Cause bits, once set, stay set until reset.
- R10: Asserting `rst_n` clears the outputs to their R1 values at once, without waiting for a clock edge. Release takes effect on the second clock edge after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| push_i | input | 1 | Push a return address |
| pop_i | input | 1 | Pop a return address |
| push_addr_i | input | 13 | Return address to push |
| wd_clear_i | input | 1 | Software watchdog clear strobe |
| tick_i | input | 1 | Interval-timer tick that advances the watchdog |
| lowv_i | input | 1 | Low-supply flag from the analog detector |
| pop_addr_o | output | 13 | Address returned by the last successful pop |
| depth_o | output | 3 | Number of occupied stack entries (0 to 5) |
| cause_o | output | 3 | Sticky causes: bit 0 watchdog, bit 1 stack, bit 2 low supply |
| fault_n_o | output | 1 | Active-low fault, to be fed back to reset |

## Verification
The bench drives the stack to each of its bounds and checks them. A push into a full stack must leave the entries intact, so a design that writes the sixth address anyway is caught when the stack is popped. A pop of an empty stack must not overwrite the last popped address.

Simultaneous push and pop are exercised; a design that lets either one win would change the depth. The watchdog is run to one tick short of its limit, where a design that is off by one faults early. The bench also sends a clear in the same cycle as a tick, where a design with the wrong priority keeps counting.

Reset is asserted while faults are latched. A design with a synchronous clear would keep the outputs stuck until the next edge.

// File: rtl/hsup_pkg.sv
package hsup_pkg;
  // Position of each cause in the sticky cause vector
  localparam int unsigned CAUSE_WDOG  = 0;
  localparam int unsigned CAUSE_STACK = 1;
  localparam int unsigned CAUSE_LOWV  = 2;
  localparam int unsigned CAUSE_W     = 3;

  typedef logic [CAUSE_W-1:0] cause_t;
endpackage

// File: rtl/hsup_rst_sync.sv
module hsup_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/hsup_stack.sv
module hsup_stack #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DEPTH  = 5,
  localparam int unsigned PTR_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  output logic [ADDR_W-1:0] pop_addr_o,
  output logic [PTR_W-1:0]  depth_o,
  output logic              err_o
);
  localparam logic [PTR_W-1:0] FULL_LVL = PTR_W'(DEPTH);

  logic [ADDR_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  depth_q, depth_d;
  logic [ADDR_W-1:0] pop_q, pop_d;
  logic [ADDR_W-1:0] top_entry;
  logic              push_only, pop_only, full, empty, push_ok, pop_ok;

  always_comb begin
    push_only = push_i & ~pop_i;
    pop_only  = pop_i & ~push_i;
    full      = (depth_q == FULL_LVL);
    empty     = (depth_q == '0);
    push_ok   = push_only & ~full;
    pop_ok    = pop_only & ~empty;
    err_o     = (push_only & full) | (pop_only & empty);
  end

  // Top entry selected by the current depth
  always_comb begin
    top_entry = '0;
    for (int i = 0; i < int'(DEPTH); i++) begin
      if (depth_q == PTR_W'(i + 1)) begin
        top_entry = mem_q[i];
      end
    end
  end

  always_comb begin
    depth_d = depth_q;
    pop_d   = pop_q;
    if (push_ok) begin
      depth_d = depth_q + 1'b1;
    end else if (pop_ok) begin
      depth_d = depth_q - 1'b1;
      pop_d   = top_entry;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      depth_q <= '0;
      pop_q   <= '0;
    end else begin
      depth_q <= depth_d;
      pop_q   <= pop_d;
    end
  end

  for (genvar g = 0; g < int'(DEPTH); g++) begin : g_slot
    localparam logic [PTR_W-1:0] SLOT = PTR_W'(g);
    logic wr_en;
    assign wr_en = push_ok & (depth_q == SLOT);
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[g] <= '0;
      end else if (wr_en) begin
        mem_q[g] <= push_addr_i;
      end
    end
  end

  assign pop_addr_o = pop_q;
  assign depth_o    = depth_q;

  // Depth never exceeds capacity
  assert_depth_bound_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    depth_q <= FULL_LVL);
  // Overflow keeps the depth and the top entry where they were
  assert_ovf_hold_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (push_i && !pop_i && full) |=> ($stable(depth_q) && $stable(top_entry)));
  // Underflow leaves the returned address alone
  assert_udf_hold_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (pop_i && !push_i && empty) |=> ($stable(pop_q) && depth_q == '0));
  // Simultaneous push and pop changes nothing
  assert_both_idle_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (push_i && pop_i) |=> ($stable(depth_q) && $stable(pop_q)));
endmodule

// File: rtl/hsup_wdog.sv
module hsup_wdog #(
  parameter int unsigned WD_LIMIT = 8,
  localparam int unsigned CNT_W = $clog2(WD_LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic tick_i,
  output logic ovf_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WD_LIMIT - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_last, cnt_en;

  always_comb begin
    at_last = (cnt_q == LAST);
    cnt_en  = clear_i | tick_i;
    ovf_o   = tick_i & ~clear_i & at_last;
    if (clear_i || at_last) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_q <= LAST);
  assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    ovf_o |=> (cnt_q == '0));
  assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    clear_i |=> (cnt_q == '0));
endmodule

// File: rtl/hsup_fault_latch.sv
module hsup_fault_latch
  import hsup_pkg::*;
(
  input  logic   clk,
  input  logic   rst_ni,
  input  logic   wd_ovf_i,
  input  logic   stk_err_i,
  input  logic   lowv_i,
  output cause_t cause_o,
  output logic   fault_n_o
);
  cause_t cause_q, cause_d, event_v;

  always_comb begin
    event_v              = '0;
    event_v[CAUSE_WDOG]  = wd_ovf_i;
    event_v[CAUSE_STACK] = stk_err_i;
    event_v[CAUSE_LOWV]  = lowv_i;
    cause_d              = cause_q | event_v;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= '0;
    end else begin
      cause_q <= cause_d;
    end
  end

  assign cause_o   = cause_q;
  assign fault_n_o = ~(|cause_q);

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (cause_q != '0) |=> ((cause_q & $past(cause_q)) == $past(cause_q)));
  assert_lowv_latch_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    lowv_i |=> cause_q[CAUSE_LOWV]);
  assert_stack_latch_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    stk_err_i |=> cause_q[CAUSE_STACK]);
endmodule

// File: rtl/hang_supervisor.sv
module hang_supervisor
  import hsup_pkg::*;
#(
  parameter int unsigned ADDR_W   = 13,
  parameter int unsigned DEPTH    = 5,
  parameter int unsigned WD_LIMIT = 8,
  localparam int unsigned PTR_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic              wd_clear_i,
  input  logic              tick_i,
  input  logic              lowv_i,
  output logic [ADDR_W-1:0] pop_addr_o,
  output logic [PTR_W-1:0]  depth_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic              fault_n_o
);
  logic   rst_s_n;
  logic   stk_err, wd_ovf;
  cause_t cause_w;

  hsup_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_s_n)
  );

  hsup_stack #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_stack (
    .clk         (clk),
    .rst_ni      (rst_s_n),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .push_addr_i (push_addr_i),
    .pop_addr_o  (pop_addr_o),
    .depth_o     (depth_o),
    .err_o       (stk_err)
  );

  hsup_wdog #(.WD_LIMIT(WD_LIMIT)) u_wdog (
    .clk     (clk),
    .rst_ni  (rst_s_n),
    .clear_i (wd_clear_i),
    .tick_i  (tick_i),
    .ovf_o   (wd_ovf)
  );

  hsup_fault_latch u_fault (
    .clk       (clk),
    .rst_ni    (rst_s_n),
    .wd_ovf_i  (wd_ovf),
    .stk_err_i (stk_err),
    .lowv_i    (lowv_i),
    .cause_o   (cause_w),
    .fault_n_o (fault_n_o)
  );

  assign cause_o = cause_w;

  // Once low, the fault line stays low until reset
  assert_fault_hold_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    !fault_n_o |=> !fault_n_o);
  // A watchdog overflow always reaches the fault line
  assert_wd_to_pin_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    wd_ovf |=> (!fault_n_o && cause_o[CAUSE_WDOG]));
endmodule

// File: tb/tb_hang_supervisor.sv
module tb_hang_supervisor;
  localparam int CLK_P = 10;
  localparam int AW    = 13;
  localparam int DEP   = 5;
  localparam int WDL   = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          push_i, pop_i, wd_clear_i, tick_i, lowv_i;
  logic [AW-1:0] push_addr_i;
  logic [AW-1:0] pop_addr_o;
  logic [2:0]    depth_o;
  logic [2:0]    cause_o;
  logic          fault_n_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [AW-1:0] m_stk [DEP];
  int            m_depth;
  logic [AW-1:0] m_pop;
  int            m_cnt;
  logic [2:0]    m_cause;

  always #(CLK_P/2) clk = ~clk;

  hang_supervisor #(.ADDR_W(AW), .DEPTH(DEP), .WD_LIMIT(WDL)) dut (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
    .push_addr_i(push_addr_i), .wd_clear_i(wd_clear_i), .tick_i(tick_i),
    .lowv_i(lowv_i), .pop_addr_o(pop_addr_o), .depth_o(depth_o),
    .cause_o(cause_o), .fault_n_o(fault_n_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void model_reset();
    for (int i = 0; i < DEP; i++) m_stk[i] = '0;
    m_depth = 0; m_pop = '0; m_cnt = 0; m_cause = '0;
  endfunction

  function automatic void model_step(input bit p, input bit q, input logic [AW-1:0] a,
                                     input bit c, input bit t, input bit l);
    bit pu, po, serr, wovf;
    pu   = p & ~q;
    po   = q & ~p;
    serr = (pu && m_depth == DEP) || (po && m_depth == 0);
    wovf = t && !c && (m_cnt == WDL - 1);
    m_cause = m_cause | {l, serr, wovf};
    if (pu && m_depth < DEP) begin
      m_stk[m_depth] = a; m_depth++;
    end else if (po && m_depth > 0) begin
      m_depth--; m_pop = m_stk[m_depth];
    end
    if (c) m_cnt = 0;
    else if (t) m_cnt = (m_cnt == WDL - 1) ? 0 : m_cnt + 1;
  endfunction

  task automatic compare_all();
    check("R2 depth", int'(depth_o), m_depth);
    check("R2 pop address", int'(pop_addr_o), int'(m_pop));
    check("R6 watchdog cause", int'(cause_o[0]), int'(m_cause[0]));
    check("R3 stack cause", int'(cause_o[1]), int'(m_cause[1]));
    check("R8 low-supply cause", int'(cause_o[2]), int'(m_cause[2]));
    check("R9 fault line", int'(fault_n_o), (m_cause == 0) ? 1 : 0);
  endtask

  // Called at a negative edge; returns at the following negative edge
  task automatic cyc(input bit p, input bit q, input logic [AW-1:0] a,
                     input bit c, input bit t, input bit l);
    push_i = p; pop_i = q; push_addr_i = a; wd_clear_i = c; tick_i = t; lowv_i = l;
    model_step(p, q, a, c, t, l);
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle_inputs();
    push_i = 0; pop_i = 0; push_addr_i = '0; wd_clear_i = 0; tick_i = 0; lowv_i = 0;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 1'b0;
    #1;
    // R10: clear happens without a clock edge
    check("R10 async depth", int'(depth_o), 0);
    check("R10 async cause", int'(cause_o), 0);
    check("R10 async fault", int'(fault_n_o), 1);
    check("R10 async pop", int'(pop_addr_o), 0);
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd20517);
    idle_inputs();
    rst_n = 1'b0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 depth", int'(depth_o), 0);
    check("R1 pop", int'(pop_addr_o), 0);
    check("R1 cause", int'(cause_o), 0);
    check("R1 fault", int'(fault_n_o), 1);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 after release", int'(fault_n_o), 1);

    // R2/R3: fill, overflow, then drain and check contents
    for (int i = 0; i < DEP; i++) cyc(1, 0, AW'(13'h100 + i), 0, 0, 0);
    check("R2 full depth", int'(depth_o), DEP);
    cyc(1, 0, 13'h1ABC, 0, 0, 0);
    check("R3 overflow cause", int'(cause_o[1]), 1);
    check("R3 overflow depth", int'(depth_o), DEP);
    for (int i = DEP - 1; i >= 0; i--) begin
      cyc(0, 1, '0, 0, 0, 0);
      check("R3 entry intact", int'(pop_addr_o), 32'h100 + i);
    end
    do_reset();

    // R4: underflow keeps last popped address
    cyc(1, 0, 13'h0777, 0, 0, 0);
    cyc(0, 1, '0, 0, 0, 0);
    check("R2 pop value", int'(pop_addr_o), 32'h777);
    check("R4 no fault before", int'(fault_n_o), 1);
    cyc(0, 1, '0, 0, 0, 0);
    check("R4 underflow cause", int'(cause_o[1]), 1);
    check("R4 pop address held", int'(pop_addr_o), 32'h777);
    check("R4 depth", int'(depth_o), 0);
    do_reset();

    // R5: push and pop together
    cyc(1, 0, 13'h0123, 0, 0, 0);
    cyc(1, 1, 13'h0456, 0, 0, 0);
    check("R5 depth", int'(depth_o), 1);
    check("R5 no fault", int'(fault_n_o), 1);
    check("R5 pop unchanged", int'(pop_addr_o), 0);
    cyc(0, 1, '0, 0, 0, 0);
    check("R5 entry kept", int'(pop_addr_o), 32'h123);
    do_reset();

    // R6/R7: watchdog limit and clear priority
    for (int i = 0; i < WDL - 1; i++) cyc(0, 0, '0, 0, 1, 0);
    check("R6 one short of limit", int'(cause_o[0]), 0);
    cyc(0, 0, '0, 1, 1, 0);
    check("R7 clear beats tick", int'(cause_o[0]), 0);
    for (int i = 0; i < WDL - 1; i++) cyc(0, 0, '0, 0, 1, 0);
    check("R7 count restarted", int'(fault_n_o), 1);
    cyc(0, 0, '0, 0, 1, 0);
    check("R6 overflow cause", int'(cause_o[0]), 1);
    check("R6 fault low", int'(fault_n_o), 0);
    do_reset();

    // R8/R9: low supply pulse latches
    cyc(0, 0, '0, 0, 0, 1);
    check("R8 low supply cause", int'(cause_o[2]), 1);
    for (int i = 0; i < 3; i++) cyc(0, 0, '0, 0, 0, 0);
    check("R9 still latched", int'(fault_n_o), 0);
    do_reset();

    // Random traffic checked against the model every cycle
    for (int k = 0; k < 4000; k++) begin
      bit p, q, c, t, l;
      p = ($urandom % 10) < 3;
      q = ($urandom % 10) < 3;
      c = ($urandom % 10) == 0;
      t = ($urandom % 2) == 1;
      l = ($urandom % 150) == 0;
      cyc(p, q, AW'($urandom), c, t, l);
      if (m_cause != 0 && ($urandom % 6) == 0) do_reset();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule